// File: doc/BRIEF.md
# Interrupt Status Aggregation Register

This block holds the 32-bit interrupt status word of a network controller and presents it on a simple host register bus at offset 0xC8. Event sources inside the controller each latch their own status bit. These sources are a software trigger, a DMA master bus error, a host-target access error, three GPIO events and a general-purpose timer wrap. The bits stay set until the host writes a one to them. A PHY interrupt level is shown in the word as a read-only mirror. A single interrupt request line is the OR of every status bit.

The software bit is not written directly. It latches when a separate software-interrupt enable input goes from low to high. A software reset input clears the two bus-error bits. Every event input is a one-cycle pulse sampled on the rising clock edge, except the PHY level and the software enable.

Top module: `irq_status_reg`

## Requirements
- R1: After hardware reset, every status bit is 0, `irq` is 0 and `bus_rdata` is 0.
- R2: Bits 31:16, bit 14 and bits 11:7 always read as 0. Writing ones to them changes nothing.
- R3: Bit 15 sets on the clock edge that sees `sw_int_en` high after it was low on the previous edge. While `sw_int_en` stays high, a cleared bit 15 does not set again.
- R4: A `dma_err` pulse sets bit 13, and a `tgt_err` pulse sets bit 12.
- R5: A pulse on `gpio_evt[k]` sets bit 4+k (GPIO 0 to bit 4, GPIO 2 to bit 6). A `tmr_wrap` pulse sets bit 3.
- R6: A write to offset 0xC8 clears each of bits 15, 13, 12, 6:4 and 3 whose data bit is 1. Bits written 0 keep their value. A write to any other offset changes no bit.
- R7: Bit 2 reads the current `phy_irq` level, and register writes have no effect on it.
- R8: A `soft_rst` pulse clears bits 13 and 12 and leaves all other bits unchanged.
- R9: When a set event and a clear (write-1 or `soft_rst`) hit the same bit in the same cycle, the bit ends up set.
- R10: `irq` is 1 exactly when some status bit, the PHY mirror included, is 1.
- R11: A read strobe at offset 0xC8 loads `bus_rdata` with the status word on the sampling edge, so it is visible in the cycle after the strobe. A read at any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| bus_addr | input | ADDR_W (8) | Host register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (32) | Write data; ones clear sticky bits |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (32) | Registered read data |
| sw_int_en | input | 1 | Software interrupt enable; its rising edge sets bit 15 |
| dma_err | input | 1 | DMA master bus error pulse |
| tgt_err | input | 1 | Host-target access error pulse |
| gpio_evt | input | 3 | GPIO event pulses |
| tmr_wrap | input | 1 | Timer rollover pulse |
| phy_irq | input | 1 | PHY interrupt level |
| soft_rst | input | 1 | Software reset pulse for the bus-error bits |
| irq | output | 1 | Combined interrupt request |

## Verification
Two things can land on the same sticky bit in one cycle: an incoming event and a clear. The clear is either a host write of one or, for the bus-error bits, a software reset. The bench provokes this by raising a GPIO pulse, a DMA error pulse or a software-enable edge at the same edge that carries the clearing write or `soft_rst`. It then reads the word back through the scoreboard and expects the bit set. Cases where only one side is present are run as well, so that a design where the clear wins, or where the set is lost, reads differently from the expected word.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
   localparam int NUM_STICKY = 7;
   // index order: timer, gpio0..2, target error, dma error, software
   localparam int STICKY_POS [NUM_STICKY] = '{3, 4, 5, 6, 12, 13, 15};
   localparam bit STICKY_SRST [NUM_STICKY] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
   localparam int PHY_POS = 2;
   localparam int SW_POS = 15;
   localparam int DMA_POS = 13;
   localparam logic [31:0] RSVD_MASK = 32'hFFFF_4F80;
endpackage

// File: rtl/irq_sticky_bit.sv
module irq_sticky_bit #(
   parameter bit SRST_CLR = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic srst_i,
   output logic q_o
);
   localparam logic USE_SRST = SRST_CLR;
   logic kill;

   assign kill = clr_i | (srst_i & USE_SRST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= set_i | (q_o & ~kill);
   end

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o); // R9
   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o); // R6
   AST_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i && !srst_i) |=> $stable(q_o)); // R6
endmodule

// File: rtl/irq_rise_det.sv
module irq_rise_det (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic rise_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~prev_q;

   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o); // R3
endmodule

// File: rtl/irq_rd_port.sv
module irq_rd_port #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_i,
   input  logic              hit_i,
   input  logic [DATA_W-1:0] stat_i,
   output logic [DATA_W-1:0] rdata_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata_o <= '0;
      else if (rd_i)  rdata_o <= hit_i ? stat_i : '0;
   end

   AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && hit_i) |=> rdata_o == $past(stat_i)); // R11
   AST_RD_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !hit_i) |=> rdata_o == '0); // R11
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int REG_OFFSET = 'hC8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              sw_int_en,
   input  logic              dma_err,
   input  logic              tgt_err,
   input  logic [2:0]        gpio_evt,
   input  logic              tmr_wrap,
   input  logic              phy_irq,
   input  logic              soft_rst,
   output logic              irq
);
   import irq_stat_pkg::*;

   localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(REG_OFFSET);

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("irq_status_reg: DATA_W must be 32");
      end
      if (REG_OFFSET >= (1 << ADDR_W)) begin : g_bad_offset
         $error("irq_status_reg: REG_OFFSET does not fit ADDR_W");
      end
   endgenerate

   logic                  hit;
   logic                  wr_hit;
   logic                  sw_rise;
   logic [NUM_STICKY-1:0] ev;
   logic [NUM_STICKY-1:0] clr;
   logic [NUM_STICKY-1:0] sticky_q;
   logic [DATA_W-1:0]     stat_w;
   logic                  unused_wdata;

   assign hit          = (bus_addr == OFFS);
   assign wr_hit       = bus_wr & hit;
   assign unused_wdata = ^bus_wdata;

   irq_rise_det u_sw_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (sw_int_en),
      .rise_o (sw_rise)
   );

   assign ev = {sw_rise, dma_err, tgt_err, gpio_evt, tmr_wrap};

   generate
      for (genvar g = 0; g < NUM_STICKY; g++) begin : g_sticky
         assign clr[g] = wr_hit & bus_wdata[STICKY_POS[g]];
         irq_sticky_bit #(.SRST_CLR(STICKY_SRST[g])) u_bit (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (ev[g]),
            .clr_i  (clr[g]),
            .srst_i (soft_rst),
            .q_o    (sticky_q[g])
         );
      end
   endgenerate

   always_comb begin
      stat_w          = '0;
      stat_w[PHY_POS] = phy_irq;
      for (int i = 0; i < NUM_STICKY; i++) begin
         stat_w[STICKY_POS[i]] = sticky_q[i];
      end
   end

   assign irq = |stat_w;

   irq_rd_port #(.DATA_W(DATA_W)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_i    (bus_rd),
      .hit_i   (hit),
      .stat_i  (stat_w),
      .rdata_o (bus_rdata)
   );

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata & RSVD_MASK) == '0); // R2
   AST_PHY_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      phy_irq |-> irq); // R10
   AST_SRST_CLEARS_DMA: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst && !dma_err) |=> !stat_w[DMA_POS]); // R8
   AST_SW_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rise |=> stat_w[SW_POS]); // R3
endmodule

// File: tb/sim_irq_status_reg.sv
`timescale 1ns/1ps
module sim_irq_status_reg;
   localparam logic [7:0] OFF   = 8'hC8;
   localparam logic [7:0] OTHER = 8'hC4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic        sw_int_en = 1'b0;
   logic        dma_err = 1'b0;
   logic        tgt_err = 1'b0;
   logic [2:0]  gpio_evt = '0;
   logic        tmr_wrap = 1'b0;
   logic        phy_irq = 1'b0;
   logic        soft_rst = 1'b0;
   logic        irq;

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sbq[$];

   int n_run = 0;
   int n_fail = 0;
   logic rd_seen = 1'b0;

   always #2.5 clk = ~clk;

   irq_status_reg u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .sw_int_en(sw_int_en), .dma_err(dma_err), .tgt_err(tgt_err),
      .gpio_evt(gpio_evt), .tmr_wrap(tmr_wrap), .phy_irq(phy_irq),
      .soft_rst(soft_rst), .irq(irq)
   );

   // monitor: a read strobe seen at a rising edge is judged at the next falling edge
   always @(posedge clk) rd_seen <= bus_rd;

   always @(negedge clk) begin
      if (rd_seen) begin
         item_t it;
         n_run++;
         if (sbq.size() == 0) begin
            n_fail++;
            $display("FAIL scoreboard empty: rdata=%h expected none", bus_rdata);
         end else begin
            it = sbq.pop_front();
            if (bus_rdata !== it.exp) begin
               n_fail++;
               $display("FAIL %s: rdata=%h expected %h", it.tag, bus_rdata, it.exp);
            end
         end
      end
   end

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(string tag, logic act, logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: irq=%b expected %b", tag, act, exp);
      end
   endtask

   task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
      item_t it;
      it.exp = exp;
      it.tag = tag;
      sbq.push_back(it);
      bus_addr = a;
      bus_rd = 1'b1;
      tick();
      bus_rd = 1'b0;
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      bus_addr = a;
      bus_wdata = d;
      bus_wr = 1'b1;
      tick();
      bus_wr = 1'b0;
      bus_wdata = '0;
   endtask

   initial begin
      #500000;
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      tick(); tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1 irq after reset", irq, 1'b0);
      rd(OFF, 32'h0, "R1 status after reset");

      // R5 gpio and timer
      gpio_evt[1] = 1'b1; tick(); gpio_evt[1] = 1'b0;
      chk("R10 irq from gpio bit", irq, 1'b1);
      rd(OFF, 32'h0000_0020, "R5 gpio1 sets bit 5");
      wr(OFF, 32'h0000_0020);
      rd(OFF, 32'h0, "R6 write-1 clears bit 5");
      chk("R10 irq low when empty", irq, 1'b0);
      tmr_wrap = 1'b1; tick(); tmr_wrap = 1'b0;
      rd(OFF, 32'h0000_0008, "R5 timer wrap sets bit 3");
      wr(OFF, 32'h0000_0000);
      rd(OFF, 32'h0000_0008, "R6 write-0 keeps bit 3");
      wr(OTHER, 32'hFFFF_FFFF);
      rd(OFF, 32'h0000_0008, "R6 other offset write ignored");
      wr(OFF, 32'h0000_0008);
      rd(OFF, 32'h0, "R6 bit 3 cleared");

      // R4 / R8 bus errors and software reset
      dma_err = 1'b1; tgt_err = 1'b1; gpio_evt[0] = 1'b1; tick();
      dma_err = 1'b0; tgt_err = 1'b0; gpio_evt[0] = 1'b0;
      rd(OFF, 32'h0000_3010, "R4 dma and target errors set bits 13,12");
      soft_rst = 1'b1; tick(); soft_rst = 1'b0;
      rd(OFF, 32'h0000_0010, "R8 soft reset clears 13,12 only");
      wr(OFF, 32'h0000_0010);

      // R3 software interrupt edge
      sw_int_en = 1'b1; tick();
      rd(OFF, 32'h0000_8000, "R3 enable rise sets bit 15");
      wr(OFF, 32'h0000_8000);
      tick(); tick();
      rd(OFF, 32'h0, "R3 held enable does not re-set");
      sw_int_en = 1'b0; tick(); sw_int_en = 1'b1; tick();
      rd(OFF, 32'h0000_8000, "R3 second rise sets bit 15");
      wr(OFF, 32'h0000_8000);

      // R7 phy mirror, R2 reserved bits
      phy_irq = 1'b1; tick();
      chk("R10 irq from phy level", irq, 1'b1);
      wr(OFF, 32'hFFFF_FFFF);
      rd(OFF, 32'h0000_0004, "R7 phy mirror survives write");
      phy_irq = 1'b0; tick();
      rd(OFF, 32'h0, "R7 phy mirror follows level; R2 reserved zero");
      chk("R10 irq low after phy drop", irq, 1'b0);

      // R9 set beats clear in the same cycle
      gpio_evt[2] = 1'b1; tick(); gpio_evt[2] = 1'b0;
      gpio_evt[2] = 1'b1; bus_addr = OFF; bus_wdata = 32'h0000_0040; bus_wr = 1'b1;
      tick();
      gpio_evt[2] = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
      rd(OFF, 32'h0000_0040, "R9 gpio2 set wins over write-1");
      dma_err = 1'b1; soft_rst = 1'b1; tick(); dma_err = 1'b0; soft_rst = 1'b0;
      rd(OFF, 32'h0000_2040, "R9 dma set wins over soft reset");
      sw_int_en = 1'b0; tick();
      sw_int_en = 1'b1; bus_addr = OFF; bus_wdata = 32'h0000_8000; bus_wr = 1'b1;
      tick();
      bus_wr = 1'b0; bus_wdata = '0;
      rd(OFF, 32'h0000_a040, "R9 software edge wins over write-1");

      // R2 full word, R11 miss address
      tgt_err = 1'b1; gpio_evt = 3'b011; tmr_wrap = 1'b1; phy_irq = 1'b1; tick();
      tgt_err = 1'b0; gpio_evt = '0; tmr_wrap = 1'b0;
      rd(OFF, 32'h0000_B07C, "R2 all sources with reserved bits zero");
      rd(OTHER, 32'h0, "R11 read at other offset returns zero");
      rd(OFF, 32'h0000_B07C, "R11 read returns status next cycle");
      wr(OFF, 32'hFFFF_FFFF);
      phy_irq = 1'b0; tick();
      rd(OFF, 32'h0, "R6 all sticky bits cleared");
      chk("R10 irq low at end", irq, 1'b0);

      tick(); tick();
      if (sbq.size() != 0) begin
         n_fail++;
         $display("FAIL scoreboard: %0d items left, expected 0", sbq.size());
      end
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule